// File: doc/BRIEF.md
# Shared-Memory Request Port Sequencer

This block is the per-port request engine that sits between one input token queue and a shared memory. It pops 16-bit tokens from the head of its queue and turns command tokens into memory reads, memory writes, burst transfers, configuration updates and lock operations. All requests from one port finish in the order they arrived. A request that cannot finish yet stalls every later token on that port.

Each port has private configuration: a port mode, the output queue that receives read results, and a partner port that supplies write data. In address-data mode the port provides both addresses and write data. In address-only mode write data comes from the partner port. In data-only mode the port only hands its tokens to whichever port uses it as a partner. The block asks the shared arbiter for each memory access, and it performs the access in the cycle the arbiter acknowledges. The clock-crossing queues and the memory array are outside this block.

Top module: `cps_port_seq`

## Requirements
- R1: After synchronous reset the port is idle. `in_pop`, `arb_req`, `mem_en`, `lend_valid` and `mtx_req` are low. The mode is address-data, the read destination is 0, the partner is 0 and the burst address is 0.
- R2: A command token carries its type in bits [15:13]: 0 read, 1 write, 2 port configuration, 3 burst-address load, 4 burst read, 5 burst write, 6 lock request, 7 lock release. For read, write and burst-address load, the token that follows is the address.
- R3: A single read reaches the memory (`mem_en` high, `mem_we` low) only in a cycle in which `out_room` is high for the configured destination. That destination appears on `mem_dest`.
- R4: In address-data mode a single write takes the command, then the address, then one data token from the same queue. The write happens only once that data token is present, and it uses the token as `mem_wdata`.
- R5: While a request waits for output room, for an arbiter acknowledge or for a lock grant, no further token is popped from the port's own queue.
- R6: A port-configuration token sets the mode from bits [1:0] (0 and 3 address-data, 1 address-only, 2 data-only), the read destination from bits [3:2] and the partner port from bits [5:4]. The partner number drives `partner_sel`.
- R7: A burst-address load sets the start address of the next burst from the token that follows it.
- R8: A burst read with count N in bits [7:0] performs N reads at consecutive ascending addresses. It performs one read per cycle while room and acknowledge are present. A count of 0 performs no access and the port moves on.
- R9: A burst write with count N performs N writes at ascending addresses. In address-data mode it takes N data tokens from the port's own queue.
- R10: In address-only mode, write data for single and burst writes comes only from the partner port. `partner_pop` is high in exactly the cycle of each write, and the port's own queue is not popped for data.
- R11: In data-only mode every token except a port-configuration token is offered on `lend_valid`/`lend_data` and is popped only when `lend_pop` is high. A port-configuration token is decoded and is not offered.
- R12: A lock request holds `mtx_req` with the lock number from bits [1:0] on `mtx_id` until `mtx_grant`, and the port blocks until then. A lock release pulses `mtx_rel` for one cycle with its lock number.
- R13: The largest burst, a count of 255, performs exactly 255 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Own input queue holds a token at its head |
| in_data | input | 16 | Head token of the own input queue |
| in_pop | output | 1 | Consume the head token of the own queue |
| lend_valid | output | 1 | Data-only mode: head token is offered to a partner |
| lend_data | output | 16 | Token offered to a partner |
| lend_pop | input | 1 | Partner consumes the offered token |
| partner_sel | output | 2 | Configured partner port number |
| partner_valid | input | 1 | Partner has a data token available |
| partner_data | input | 16 | Partner data token |
| partner_pop | output | 1 | Consume the partner data token |
| out_room | input | 4 | Per output queue: room for one result |
| arb_req | output | 1 | Request one memory access this cycle |
| arb_ack | input | 1 | Arbiter grants the access this cycle |
| mem_en | output | 1 | Memory access performed this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_dest | output | 2 | Output queue for read result |
| mtx_req | output | 1 | Lock request pending |
| mtx_rel | output | 1 | One-cycle lock release |
| mtx_id | output | 2 | Lock number for request or release |
| mtx_grant | input | 1 | Lock granted |

## Verification
The hardest situation to create is an address-only write whose data is still missing while other tokens wait behind it. The command must already have been consumed from the own queue, and the partner queue must stay empty for several cycles. The stimulus configures the partner mode and queues a write command and its address. It holds the partner queue empty and checks that nothing reaches memory and that the own queue stays put. It then supplies a single partner token and checks both the write and the partner pop. A similar sequence switches a port into data-only mode, then brings it back with a configuration token that must be decoded rather than lent.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int TOK_W   = 16;
    localparam int NPORTS  = 4;
    localparam int NMUTEX  = 4;
    localparam int SEL_W   = $clog2(NPORTS);
    localparam int MTX_W   = $clog2(NMUTEX);

    // token field positions
    localparam int OP_HI   = 15;
    localparam int OP_LO   = 13;
    localparam int MODE_LO = 0;
    localparam int DEST_LO = 2;
    localparam int PTN_LO  = 4;
    localparam int CFG_W   = PTN_LO + SEL_W;

    typedef enum logic [2:0] {
        OP_RD    = 3'd0,
        OP_WR    = 3'd1,
        OP_CFGP  = 3'd2,
        OP_CFGA  = 3'd3,
        OP_BRD   = 3'd4,
        OP_BWR   = 3'd5,
        OP_MLOCK = 3'd6,
        OP_MFREE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PM_ADDR_DATA = 2'd0,
        PM_ADDR_ONLY = 2'd1,
        PM_DATA_ONLY = 2'd2,
        PM_RSVD      = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_BRD,
        ST_BWR,
        ST_MTX
    } st_e;

    typedef struct packed {
        pmode_e             mode;
        logic [SEL_W-1:0]   dest;
        logic [SEL_W-1:0]   ptn;
    } pcfg_t;

    function automatic pcfg_t cfg_unpack(input logic [CFG_W-1:0] f);
        pcfg_t c;
        c.mode = pmode_e'(f[MODE_LO +: 2]);
        c.dest = f[DEST_LO +: SEL_W];
        c.ptn  = f[PTN_LO +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/cps_cfg_regs.sv
module cps_cfg_regs
    import cps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_field,
    output pcfg_t             cfg
);

    pcfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= PM_ADDR_DATA;
            cfg_q.dest <= '0;
            cfg_q.ptn  <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_unpack(cfg_field);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cps_addr_gen.sv
module cps_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= load_addr;
        else if (step) addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;

    AST_AGEN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && step)); // R7

endmodule

// File: rtl/cps_wsrc.sv
module cps_wsrc
    import cps_pkg::*;
(
    input  logic              from_partner,
    input  logic              own_valid,
    input  logic [TOK_W-1:0]  own_data,
    input  logic              ptn_valid,
    input  logic [TOK_W-1:0]  ptn_data,
    input  logic              take,
    output logic              src_valid,
    output logic [TOK_W-1:0]  src_data,
    output logic              own_pop,
    output logic              ptn_pop
);

    always_comb begin
        if (from_partner) begin
            src_valid = ptn_valid;
            src_data  = ptn_data;
        end else begin
            src_valid = own_valid;
            src_data  = own_data;
        end
        own_pop = take && !from_partner;
        ptn_pop = take &&  from_partner;
    end

endmodule

// File: rtl/cps_port_seq.sv
module cps_port_seq
    import cps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [TOK_W-1:0]     in_data,
    output logic                 in_pop,
    output logic                 lend_valid,
    output logic [TOK_W-1:0]     lend_data,
    input  logic                 lend_pop,
    output logic [SEL_W-1:0]     partner_sel,
    input  logic                 partner_valid,
    input  logic [TOK_W-1:0]     partner_data,
    output logic                 partner_pop,
    input  logic [NPORTS-1:0]    out_room,
    output logic                 arb_req,
    input  logic                 arb_ack,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [TOK_W-1:0]     mem_wdata,
    output logic [SEL_W-1:0]     mem_dest,
    output logic                 mtx_req,
    output logic                 mtx_rel,
    output logic [MTX_W-1:0]     mtx_id,
    input  logic                 mtx_grant
);

    st_e               state_q;
    op_e               kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MTX_W-1:0]  mid_q;

    pcfg_t             cfg;
    op_e               head_op;
    logic [CNT_W-1:0]  head_cnt;
    logic              data_only;
    logic              idle_take;
    logic              cfg_we;
    logic              agen_load;
    logic              agen_step;
    logic [ADDR_W-1:0] agen_addr;
    logic              in_burst;
    logic              in_write;
    logic              src_valid;
    logic [TOK_W-1:0]  src_data;
    logic              own_data_pop;

    assign head_op   = op_e'(in_data[OP_HI:OP_LO]);
    assign head_cnt  = in_data[CNT_W-1:0];
    assign data_only = (cfg.mode == PM_DATA_ONLY);

    // a head token is decoded when idle, except plain data in data-only mode
    assign idle_take = (state_q == ST_IDLE) && in_valid &&
                       (!data_only || head_op == OP_CFGP);
    assign cfg_we    = idle_take && (head_op == OP_CFGP);

    assign lend_valid = (state_q == ST_IDLE) && data_only && in_valid &&
                        (head_op != OP_CFGP);
    assign lend_data  = in_data;

    assign in_burst  = (state_q == ST_BRD) || (state_q == ST_BWR);
    assign in_write  = (state_q == ST_WR)  || (state_q == ST_BWR);
    assign agen_load = (state_q == ST_ADDR) && (kind_q == OP_CFGA) && in_valid;
    assign agen_step = mem_en && in_burst;

    cps_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_field (in_data[CFG_W-1:0]),
        .cfg       (cfg)
    );

    cps_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk       (clk),
        .rst       (rst),
        .load      (agen_load),
        .load_addr (in_data[ADDR_W-1:0]),
        .step      (agen_step),
        .addr      (agen_addr)
    );

    cps_wsrc u_wsrc (
        .from_partner (cfg.mode == PM_ADDR_ONLY),
        .own_valid    (in_valid),
        .own_data     (in_data),
        .ptn_valid    (partner_valid),
        .ptn_data     (partner_data),
        .take         (mem_en && mem_we),
        .src_valid    (src_valid),
        .src_data     (src_data),
        .own_pop      (own_data_pop),
        .ptn_pop      (partner_pop)
    );

    always_comb begin
        unique case (state_q)
            ST_RD, ST_BRD: arb_req = out_room[cfg.dest];
            ST_WR, ST_BWR: arb_req = src_valid;
            default:       arb_req = 1'b0;
        endcase
    end

    assign mem_en    = arb_req && arb_ack;
    assign mem_we    = in_write;
    assign mem_addr  = in_burst ? agen_addr : addr_q;
    assign mem_wdata = src_data;
    assign mem_dest  = cfg.dest;

    assign in_pop = idle_take ||
                    (lend_valid && lend_pop) ||
                    ((state_q == ST_ADDR) && in_valid) ||
                    own_data_pop;

    assign partner_sel = cfg.ptn;
    assign mtx_req     = (state_q == ST_MTX);
    assign mtx_rel     = idle_take && (head_op == OP_MFREE);
    assign mtx_id      = mtx_req ? mid_q : in_data[MTX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= OP_RD;
            addr_q  <= '0;
            cnt_q   <= '0;
            mid_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (idle_take) begin
                    unique case (head_op)
                        OP_RD, OP_WR, OP_CFGA: begin
                            kind_q  <= head_op;
                            state_q <= ST_ADDR;
                        end
                        OP_BRD: if (head_cnt != '0) begin
                            cnt_q   <= head_cnt;
                            state_q <= ST_BRD;
                        end
                        OP_BWR: if (head_cnt != '0) begin
                            cnt_q   <= head_cnt;
                            state_q <= ST_BWR;
                        end
                        OP_MLOCK: begin
                            mid_q   <= in_data[MTX_W-1:0];
                            state_q <= ST_MTX;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
                ST_ADDR: if (in_valid) begin
                    addr_q <= in_data[ADDR_W-1:0];
                    if (kind_q == OP_RD)      state_q <= ST_RD;
                    else if (kind_q == OP_WR) state_q <= ST_WR;
                    else                      state_q <= ST_IDLE;
                end
                ST_RD, ST_WR: if (mem_en) state_q <= ST_IDLE;
                ST_BRD, ST_BWR: if (mem_en) begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
                end
                ST_MTX: if (mtx_grant) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_READ_ROOM: assert property (@(posedge clk) disable iff (rst)
        mem_en && !mem_we |-> out_room[mem_dest]); // R3
    AST_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        mem_en && mem_we |-> (in_pop || partner_pop)); // R4
    AST_READ_STALL_NO_POP: assert property (@(posedge clk) disable iff (rst)
        arb_req && !arb_ack && !mem_we |-> !in_pop); // R5
    AST_LOCK_STALL_NO_POP: assert property (@(posedge clk) disable iff (rst)
        mtx_req |-> !in_pop); // R5
    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(in_pop && partner_pop)); // R10
    AST_LEND_QUIET: assert property (@(posedge clk) disable iff (rst)
        lend_valid |-> !arb_req && !mtx_req); // R11
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        mtx_req && !mtx_grant |=> mtx_req && $stable(mtx_id)); // R12

endmodule

// File: tb/sim_cps_port_seq.sv
module sim_cps_port_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_pop;
    logic        lend_valid;
    logic [15:0] lend_data;
    logic        lend_pop = 1'b0;
    logic [1:0]  partner_sel;
    logic        partner_valid = 1'b0;
    logic [15:0] partner_data = '0;
    logic        partner_pop;
    logic [3:0]  out_room = 4'hF;
    logic        arb_req;
    logic        arb_ack = 1'b1;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_dest;
    logic        mtx_req;
    logic        mtx_rel;
    logic [1:0]  mtx_id;
    logic        mtx_grant = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] qi[$];
    logic [15:0] qp[$];
    bit pi_s = 0;
    bit pp_s = 0;

    int         cyc = 0;
    int         log_n = 0;
    logic       ev_we[512];
    logic [15:0] ev_addr[512];
    logic [15:0] ev_data[512];
    logic [1:0] ev_dest[512];
    int         ev_cyc[512];
    int         rel_cnt = 0;
    logic [1:0] rel_id = '0;

    always #2 clk = ~clk;

    cps_port_seq u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_pop(in_pop),
        .lend_valid(lend_valid), .lend_data(lend_data), .lend_pop(lend_pop),
        .partner_sel(partner_sel), .partner_valid(partner_valid),
        .partner_data(partner_data), .partner_pop(partner_pop),
        .out_room(out_room), .arb_req(arb_req), .arb_ack(arb_ack),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_dest(mem_dest),
        .mtx_req(mtx_req), .mtx_rel(mtx_rel), .mtx_id(mtx_id),
        .mtx_grant(mtx_grant)
    );

    task automatic refresh();
        in_valid      = (qi.size() != 0);
        in_data       = (qi.size() != 0) ? qi[0] : 16'h0;
        partner_valid = (qp.size() != 0);
        partner_data  = (qp.size() != 0) ? qp[0] : 16'h0;
    endtask

    // monitor: sample outputs mid-cycle
    initial forever begin
        @(negedge clk);
        pi_s = in_pop;
        pp_s = partner_pop;
        if (mem_en && log_n < 512) begin
            ev_we[log_n]   = mem_we;
            ev_addr[log_n] = mem_addr;
            ev_data[log_n] = mem_wdata;
            ev_dest[log_n] = mem_dest;
            ev_cyc[log_n]  = cyc;
            log_n++;
        end
        if (mtx_rel) begin
            rel_cnt++;
            rel_id = mtx_id;
        end
    end

    // queue model: pops happen just after the edge that consumed them
    initial forever begin
        @(posedge clk);
        cyc++;
        #1;
        if (pi_s && qi.size() != 0) void'(qi.pop_front());
        if (pp_s && qp.size() != 0) void'(qp.pop_front());
        refresh();
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push(input logic [15:0] t);
        qi.push_back(t);
        refresh();
    endtask

    task automatic push_p(input logic [15:0] t);
        qp.push_back(t);
        refresh();
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic t_reset();
        chk_eq("R1", "in_pop", in_pop, 0);
        chk_eq("R1", "arb_req", arb_req, 0);
        chk_eq("R1", "mem_en", mem_en, 0);
        chk_eq("R1", "lend_valid", lend_valid, 0);
        chk_eq("R1", "mtx_req", mtx_req, 0);
        chk_eq("R1", "partner_sel", partner_sel, 0);
    endtask

    task automatic t_write();
        log_n = 0;
        push(16'h2000); push(16'h0010); push(16'hBEEF);
        tick(8);
        chk_eq("R4", "write count", log_n, 1);
        chk_eq("R2", "write flag", ev_we[0], 1);
        chk_eq("R4", "write addr", ev_addr[0], 16'h0010);
        chk_eq("R4", "write data", ev_data[0], 16'hBEEF);
        push(16'h2000); push(16'h0011);
        tick(8);
        chk_eq("R4", "write waits for data", log_n, 1);
        push(16'h0A0A);
        tick(5);
        chk_eq("R4", "late data write count", log_n, 2);
        chk_eq("R4", "late data value", ev_data[1], 16'h0A0A);
        chk_eq("R4", "late data addr", ev_addr[1], 16'h0011);
    endtask

    task automatic t_read_room();
        push(16'h4008);              // dest 2
        tick(4);
        log_n = 0;
        out_room = 4'b1011;
        push(16'h0000); push(16'h0033); push(16'h2000);
        tick(10);
        chk_eq("R3", "read without room", log_n, 0);
        chk_eq("R5", "tokens held behind read", qi.size(), 1);
        chk_eq("R3", "arb_req without room", arb_req, 0);
        out_room = 4'hF;
        tick(4);
        chk_eq("R3", "read count", log_n, 1);
        chk_eq("R3", "read flag", ev_we[0], 0);
        chk_eq("R3", "read addr", ev_addr[0], 16'h0033);
        chk_eq("R6", "read dest", ev_dest[0], 2);
        push(16'h0044); push(16'h5555);
        tick(8);
        chk_eq("R5", "queued write after read", log_n, 2);
        chk_eq("R5", "queued write addr", ev_addr[1], 16'h0044);
        push(16'h4000);
        tick(4);
    endtask

    task automatic t_ack();
        log_n = 0;
        arb_ack = 1'b0;
        push(16'h0000); push(16'h0077); push(16'h0000);
        tick(8);
        chk_eq("R5", "no access without ack", log_n, 0);
        chk_eq("R5", "no pop without ack", qi.size(), 1);
        arb_ack = 1'b1;
        tick(3);
        chk_eq("R3", "read after ack", log_n, 1);
        chk_eq("R3", "read after ack addr", ev_addr[0], 16'h0077);
        push(16'h0078);
        tick(6);
        chk_eq("R3", "second read addr", ev_addr[1], 16'h0078);
    endtask

    task automatic t_burst_rd();
        log_n = 0;
        push(16'h6000); push(16'h0100); push(16'h8004);
        tick(12);
        chk_eq("R8", "burst read count", log_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk_eq("R7", "burst read addr", ev_addr[i], 16'h0100 + i);
            chk_eq("R8", "burst read cycle", ev_cyc[i], ev_cyc[0] + i);
            chk_eq("R8", "burst read flag", ev_we[i], 0);
        end
        log_n = 0;
        push(16'h8000); push(16'h0000); push(16'h0005);
        tick(10);
        chk_eq("R8", "zero-count burst then read", log_n, 1);
        chk_eq("R8", "read after zero burst addr", ev_addr[0], 16'h0005);
    endtask

    task automatic t_burst_wr();
        log_n = 0;
        push(16'h6000); push(16'h0200); push(16'hA003);
        push(16'h0001); push(16'h0002); push(16'h0003);
        tick(14);
        chk_eq("R9", "burst write count", log_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk_eq("R9", "burst write addr", ev_addr[i], 16'h0200 + i);
            chk_eq("R9", "burst write data", ev_data[i], i + 1);
            chk_eq("R9", "burst write flag", ev_we[i], 1);
        end
    endtask

    task automatic t_addr_only();
        push(16'h4031);              // address-only, partner 3
        tick(4);
        chk_eq("R6", "partner_sel", partner_sel, 3);
        log_n = 0;
        push(16'h2000); push(16'h0050); push(16'h0000);
        tick(10);
        chk_eq("R10", "write waits for partner", log_n, 0);
        chk_eq("R10", "own queue untouched", qi.size(), 1);
        push_p(16'h1234);
        tick(4);
        chk_eq("R10", "partner write count", log_n, 1);
        chk_eq("R10", "partner write data", ev_data[0], 16'h1234);
        chk_eq("R10", "partner write addr", ev_addr[0], 16'h0050);
        chk_eq("R10", "partner token consumed", qp.size(), 0);
        // leftover 0x0000 started a read: give it an address
        push(16'h0060);
        tick(6);
        chk_eq("R10", "read in address-only mode", ev_addr[1], 16'h0060);
        log_n = 0;
        push(16'h6000); push(16'h0300); push(16'hA002);
        push_p(16'h0007); push_p(16'h0008);
        tick(12);
        chk_eq("R10", "partner burst count", log_n, 2);
        chk_eq("R10", "partner burst data", ev_data[1], 16'h0008);
        chk_eq("R10", "partner burst addr", ev_addr[1], 16'h0301);
        push(16'h4000);
        tick(4);
    endtask

    task automatic t_data_only();
        push(16'h4002);
        tick(4);
        log_n = 0;
        push(16'h2000);
        tick(2);
        chk_eq("R11", "token lent", lend_valid, 1);
        chk_eq("R11", "lent data", lend_data, 16'h2000);
        chk_eq("R11", "no arb while lending", arb_req, 0);
        tick(4);
        chk_eq("R11", "lent token not executed", log_n, 0);
        chk_eq("R11", "lent token held", qi.size(), 1);
        lend_pop = 1'b1;
        tick(1);
        lend_pop = 1'b0;
        tick(2);
        chk_eq("R11", "lent token popped", qi.size(), 0);
        push(16'h4000);
        tick(1);
        chk_eq("R11", "config not lent", lend_valid, 0);
        tick(3);
        push(16'h0000); push(16'h0009);
        tick(8);
        chk_eq("R11", "config decoded in data-only", log_n, 1);
        chk_eq("R11", "read after leaving data-only", ev_addr[0], 16'h0009);
    endtask

    task automatic t_mutex();
        log_n = 0;
        push(16'hC002);
        tick(4);
        chk_eq("R12", "lock requested", mtx_req, 1);
        chk_eq("R12", "lock id", mtx_id, 2);
        push(16'h0000); push(16'h0066);
        tick(6);
        chk_eq("R12", "lock still held", mtx_req, 1);
        chk_eq("R5", "nothing runs before grant", log_n, 0);
        chk_eq("R5", "no pop before grant", qi.size(), 2);
        mtx_grant = 1'b1;
        tick(1);
        mtx_grant = 1'b0;
        tick(8);
        chk_eq("R12", "lock released from wait", mtx_req, 0);
        chk_eq("R12", "read after grant", log_n, 1);
        rel_cnt = 0;
        push(16'hE001);
        tick(5);
        chk_eq("R12", "release pulses", rel_cnt, 1);
        chk_eq("R12", "release id", rel_id, 1);
    endtask

    task automatic t_burst255();
        log_n = 0;
        push(16'h6000); push(16'h0000); push(16'h80FF);
        tick(275);
        chk_eq("R13", "max burst count", log_n, 255);
        chk_eq("R13", "max burst first", ev_addr[0], 0);
        chk_eq("R13", "max burst last", ev_addr[254], 16'h00FE);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_write();
        t_read_room();
        t_ack();
        t_burst_rd();
        t_burst_wr();
        t_addr_only();
        t_data_only();
        t_mutex();
        t_burst255();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule